// File: doc/BRIEF.md
# Staggered Half-Word Forwarding Adder

This integer execution unit adds and subtracts 32-bit operands as two 16-bit halves on consecutive ticks. One tick is one cycle of `clk_i`. The low half of a result is registered in the tick after issue. It can be picked up at once by the next micro-op through a forward-select flag on either source. The high half follows one tick later and uses the carry held over from the low half. A dependent operation's low half is computed in that same tick. A chain of dependent adds therefore issues one per tick with no stall.

The flags (zero, carry, sign, signed overflow) describe the whole 32-bit result. They appear one tick after the high half. Shifts need the high-order bits first, so they take a separate slow port and return their full result a fixed four ticks after issue. A fast operation that asks for a forwarded operand while a shift is still in flight is held with `stall_o`. Once the shift returns, its result becomes the forwarded value.

Top module: `stag_adder`

## Requirements
- R1: A fast operation accepted in cycle k drives `lo_valid_o` in cycle k+1, with `lo_o` equal to bits 15:0 of its result and `lo_tag_o` equal to its tag.
- R2: In cycle k+2 the same operation drives `hi_valid_o`, `hi_o` (bits 31:16 of the result, including the carry out of the low half) and `hi_tag_o`.
- R3: `op_i` encoding: 0 is a+b, 1 is a-b (two's complement), 2 is logical shift left of a by b[4:0], 3 is logical shift right of a by b[4:0].
- R4: When `fwd_a_i` or `fwd_b_i` is set, that source takes the latest forwarded result instead of `a_i` or `b_i`. For fast operations this is the previous fast result. A dependent fast operation may issue in the very next cycle, so a chain of dependent adds sustains one operation per cycle without stalling.
- R5: In cycle k+3 `flags_valid_o` is high and `flags_o` holds, from bit 3 down to bit 0: zero (all 32 result bits clear), carry (carry out of bit 31; for subtract this is the no-borrow carry of a + ~b + 1), sign (result bit 31) and signed overflow. `flags_tag_o` equals the tag.
- R6: A shift accepted in cycle k produces no low, high or flag output. It drives `slow_valid_o`, `slow_o` and `slow_tag_o` in cycle k+4.
- R7: The forward-select flags have no effect on shifts. They always use `a_i` and `b_i`.
- R8: `stall_o` is high, and the operation is not accepted, exactly when a valid add or subtract has a forward flag set while a shift issued in one of the previous three cycles has not yet returned. Independent fast operations and shifts are never stalled.
- R9: The forwarded value is that of the most recent completion. A fast operation's low-half tick counts as its completion, and a shift completes in the cycle before `slow_valid_o` rises. When both happen on the same edge, the fast result wins.
- R10: During and right after reset all valid outputs and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Micro-op present |
| op_i | input | 2 | Operation code (R3) |
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand or shift amount |
| fwd_a_i | input | 1 | Take first source from the forwarded result |
| fwd_b_i | input | 1 | Take second source from the forwarded result |
| tag_i | input | 4 | Destination tag |
| stall_o | output | 1 | Micro-op held, not accepted |
| lo_valid_o | output | 1 | Low half valid |
| lo_o | output | 16 | Low half of result |
| lo_tag_o | output | 4 | Tag of low half |
| hi_valid_o | output | 1 | High half valid |
| hi_o | output | 16 | High half of result |
| hi_tag_o | output | 4 | Tag of high half |
| flags_valid_o | output | 1 | Flags valid |
| flags_o | output | 4 | Zero, carry, sign, overflow |
| flags_tag_o | output | 4 | Tag of flags |
| slow_valid_o | output | 1 | Shift result valid |
| slow_o | output | 32 | Shift result |
| slow_tag_o | output | 4 | Tag of shift result |

## Verification
The assertions check several timing rules on every cycle. Each low half is followed one tick later by a high half with the same tag, and each high half by flags one tick after that. A stalled operation never produces a low half. The zero and sign flags agree with the high half seen the tick before. Only the bench's scenarios can show the rest. That covers arithmetic correctness across corner operands, carry crossing between halves inside long dependent chains, and the exact stall duration behind a shift. It also covers which value is forwarded when a shift return coincides with a fast completion.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_SHL = 2'd2,
    OP_SHR = 2'd3
  } sa_op_e;

  localparam int FLG_Z = 3;
  localparam int FLG_C = 2;
  localparam int FLG_N = 1;
  localparam int FLG_V = 0;
endpackage

// File: rtl/sa_half_add.sv
module sa_half_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  always_comb {c_o, s_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};
endmodule

// File: rtl/sa_slow_unit.sv
module sa_slow_unit #(
  parameter int DW  = 32,
  parameter int TW  = 4,
  parameter int LAT = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_v_i,
  input  logic                  shr_i,
  input  logic [DW-1:0]         a_i,
  input  logic [$clog2(DW)-1:0] amt_i,
  input  logic [TW-1:0]         tag_i,
  output logic                  busy_o,
  output logic                  ret_o,
  output logic                  out_v_o,
  output logic [DW-1:0]         out_o,
  output logic [TW-1:0]         out_tag_o
);
  logic [LAT-1:0] v_q;
  logic [DW-1:0]  d_q [LAT];
  logic [TW-1:0]  t_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0] <= 1'b0;
      d_q[0] <= '0;
      t_q[0] <= '0;
    end else begin
      v_q[0] <= in_v_i;
      if (in_v_i) begin
        d_q[0] <= shr_i ? (a_i >> amt_i) : (a_i << amt_i);
        t_q[0] <= tag_i;
      end
    end
  end

  // data advances only with a valid op, so the last stage holds the last return
  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[i] <= 1'b0;
        d_q[i] <= '0;
        t_q[i] <= '0;
      end else begin
        v_q[i] <= v_q[i-1];
        if (v_q[i-1]) begin
          d_q[i] <= d_q[i-1];
          t_q[i] <= t_q[i-1];
        end
      end
    end
  end

  assign busy_o    = |v_q[LAT-2:0];
  assign ret_o     = v_q[LAT-2];
  assign out_v_o   = v_q[LAT-1];
  assign out_o     = d_q[LAT-1];
  assign out_tag_o = t_q[LAT-1];
endmodule

// File: rtl/stag_adder.sv
module stag_adder
  import sa_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int SLOW_LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              fwd_a_i,
  input  logic              fwd_b_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              stall_o,
  output logic              lo_valid_o,
  output logic [DATA_W/2-1:0] lo_o,
  output logic [TAG_W-1:0]  lo_tag_o,
  output logic              hi_valid_o,
  output logic [DATA_W/2-1:0] hi_o,
  output logic [TAG_W-1:0]  hi_tag_o,
  output logic              flags_valid_o,
  output logic [3:0]        flags_o,
  output logic [TAG_W-1:0]  flags_tag_o,
  output logic              slow_valid_o,
  output logic [DATA_W-1:0] slow_o,
  output logic [TAG_W-1:0]  slow_tag_o
);
  localparam int HW  = DATA_W / 2;
  localparam int SHW = $clog2(DATA_W);

  sa_op_e op_e;
  logic   is_slow, is_sub, is_shr, issue_fast, issue_slow;
  logic   slow_busy, slow_ret, last_slow_q;

  always_comb begin
    op_e    = sa_op_e'(op_i);
    is_slow = (op_e == OP_SHL) || (op_e == OP_SHR);
    is_sub  = (op_e == OP_SUB);
    is_shr  = (op_e == OP_SHR);
  end

  assign stall_o    = valid_i & ~is_slow & (fwd_a_i | fwd_b_i) & slow_busy;
  assign issue_fast = valid_i & ~is_slow & ~stall_o;
  assign issue_slow = valid_i & is_slow;

  // ---------------- low tick ----------------
  logic [HW-1:0] lo_q, hi_q, fwd_lo, a_lo, b_lo, lo_sum;
  logic          lo_co;
  logic          lo_v_q;
  logic [TAG_W-1:0] lo_tag_q;

  assign fwd_lo = last_slow_q ? slow_o[HW-1:0] : lo_q;
  assign a_lo   = fwd_a_i ? fwd_lo : a_i[HW-1:0];
  assign b_lo   = (fwd_b_i ? fwd_lo : b_i[HW-1:0]) ^ {HW{is_sub}};

  sa_half_add #(.W(HW)) u_lo (
    .a_i(a_lo), .b_i(b_lo), .c_i(is_sub), .s_o(lo_sum), .c_o(lo_co)
  );

  // high-half operands held across the tick
  logic          s_sub, s_fa, s_fb, s_c, s_lz;
  logic [HW-1:0] s_a_hi, s_b_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_v_q <= 1'b0; lo_q <= '0; lo_tag_q <= '0;
      s_sub <= 1'b0; s_fa <= 1'b0; s_fb <= 1'b0; s_c <= 1'b0; s_lz <= 1'b0;
      s_a_hi <= '0; s_b_hi <= '0;
    end else begin
      lo_v_q <= issue_fast;
      if (issue_fast) begin
        lo_q     <= lo_sum;
        lo_tag_q <= tag_i;
        s_sub    <= is_sub;
        s_c      <= lo_co;
        s_lz     <= (lo_sum == '0);
        // a returned shift is captured whole; a fast producer's high half is read next tick
        s_fa     <= fwd_a_i & ~last_slow_q;
        s_fb     <= fwd_b_i & ~last_slow_q;
        s_a_hi   <= fwd_a_i ? slow_o[DATA_W-1:HW] : a_i[DATA_W-1:HW];
        s_b_hi   <= fwd_b_i ? slow_o[DATA_W-1:HW] : b_i[DATA_W-1:HW];
      end
    end
  end

  // fast low completion beats a shift returning on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         last_slow_q <= 1'b0;
    else if (issue_fast) last_slow_q <= 1'b0;
    else if (slow_ret)   last_slow_q <= 1'b1;
  end

  // ---------------- high tick ----------------
  logic [HW-1:0] a_hi, b_hi, hi_sum;
  logic          hi_co, hi_v_q;
  logic [TAG_W-1:0] hi_tag_q;
  logic [3:0]    pre_f;

  assign a_hi = s_fa ? hi_q : s_a_hi;
  assign b_hi = (s_fb ? hi_q : s_b_hi) ^ {HW{s_sub}};

  sa_half_add #(.W(HW)) u_hi (
    .a_i(a_hi), .b_i(b_hi), .c_i(s_c), .s_o(hi_sum), .c_o(hi_co)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_v_q <= 1'b0; hi_q <= '0; hi_tag_q <= '0; pre_f <= '0;
    end else begin
      hi_v_q <= lo_v_q;
      if (lo_v_q) begin
        hi_q         <= hi_sum;
        hi_tag_q     <= lo_tag_q;
        pre_f[FLG_Z] <= s_lz & (hi_sum == '0);
        pre_f[FLG_C] <= hi_co;
        pre_f[FLG_N] <= hi_sum[HW-1];
        pre_f[FLG_V] <= (a_hi[HW-1] == b_hi[HW-1]) & (hi_sum[HW-1] != a_hi[HW-1]);
      end
    end
  end

  // ---------------- flag tick ----------------
  logic       f_v_q;
  logic [3:0] f_q;
  logic [TAG_W-1:0] f_tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_v_q <= 1'b0; f_q <= '0; f_tag_q <= '0;
    end else begin
      f_v_q <= hi_v_q;
      if (hi_v_q) begin
        f_q     <= pre_f;
        f_tag_q <= hi_tag_q;
      end
    end
  end

  // ---------------- slow port ----------------
  sa_slow_unit #(.DW(DATA_W), .TW(TAG_W), .LAT(SLOW_LAT)) u_slow (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_v_i(issue_slow), .shr_i(is_shr),
    .a_i(a_i), .amt_i(b_i[SHW-1:0]), .tag_i(tag_i),
    .busy_o(slow_busy), .ret_o(slow_ret),
    .out_v_o(slow_valid_o), .out_o(slow_o), .out_tag_o(slow_tag_o)
  );

  assign lo_valid_o    = lo_v_q;
  assign lo_o          = lo_q;
  assign lo_tag_o      = lo_tag_q;
  assign hi_valid_o    = hi_v_q;
  assign hi_o          = hi_q;
  assign hi_tag_o      = hi_tag_q;
  assign flags_valid_o = f_v_q;
  assign flags_o       = f_q;
  assign flags_tag_o   = f_tag_q;

  // R2
  lo_then_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_valid_o |=> hi_valid_o && hi_tag_o == $past(lo_tag_o));
  // R5
  hi_then_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_valid_o |=> flags_valid_o && flags_tag_o == $past(hi_tag_o));
  // R8
  stall_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !lo_valid_o);
  // R5
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_valid_o && flags_o[FLG_Z]) |-> $past(hi_o) == '0);
  // R5
  sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_valid_o |-> flags_o[FLG_N] == $past(hi_o[HW-1]));
endmodule

// File: tb/stag_adder_test.sv
module stag_adder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        valid = 1'b0, fa = 1'b0, fb = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  tag = '0;

  logic        stall_o, lo_valid_o, hi_valid_o, flags_valid_o, slow_valid_o;
  logic [15:0] lo_o, hi_o;
  logic [3:0]  lo_tag_o, hi_tag_o, flags_o, flags_tag_o, slow_tag_o;
  logic [31:0] slow_o;

  stag_adder uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .fwd_a_i(fa), .fwd_b_i(fb), .tag_i(tag), .stall_o(stall_o),
    .lo_valid_o(lo_valid_o), .lo_o(lo_o), .lo_tag_o(lo_tag_o),
    .hi_valid_o(hi_valid_o), .hi_o(hi_o), .hi_tag_o(hi_tag_o),
    .flags_valid_o(flags_valid_o), .flags_o(flags_o), .flags_tag_o(flags_tag_o),
    .slow_valid_o(slow_valid_o), .slow_o(slow_o), .slow_tag_o(slow_tag_o)
  );

  int    n_chk = 0, n_err = 0, cyc = 0;
  bit    done = 0;
  string scen = "reset";

  // bench model state
  logic [31:0] last_val = '0;
  bit          st1_v = 0, st2_v = 0, st3_v = 0;
  logic [31:0] st1_r = '0, st2_r = '0;
  logic [3:0]  st1_f = '0, st2_f = '0, st3_f = '0;
  logic [3:0]  st1_t = '0, st2_t = '0, st3_t = '0;
  bit          sv [4] = '{0, 0, 0, 0};
  logic [31:0] sr [4] = '{0, 0, 0, 0};
  logic [3:0]  stg[4] = '{0, 0, 0, 0};
  logic [3:0]  tag_ctr = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (%s) at cycle %0d: actual %h expected %h", req, scen, cyc, act, exp);
    end
  endtask

  task automatic tick(output bit stalled);
    logic [32:0] sum;
    logic [31:0] opa, opb, bx, sres;
    logic [3:0]  f;
    bit fast_acc, slow_acc;
    #1;
    stalled = valid && !op[1] && (fa || fb) && (sv[0] || sv[1] || sv[2]);
    chk("R8 stall", 32'(stall_o), 32'(stalled));
    fast_acc = valid && !op[1] && !stalled;
    slow_acc = valid && op[1];
    opa = fa ? last_val : a;
    opb = fb ? last_val : b;
    bx  = op[0] ? ~opb : opb;
    sum = {1'b0, opa} + {1'b0, bx} + 33'(op[0]);
    f   = {sum[31:0] == 32'd0, sum[32], sum[31], (opa[31] == bx[31]) && (sum[31] != opa[31])};
    sres = op[0] ? (a >> b[4:0]) : (a << b[4:0]);
    // R9: most recent completion is forwarded, fast wins a tie
    if (fast_acc) last_val = sum[31:0];
    else if (sv[2]) last_val = sr[2];
    st3_v = st2_v; st3_f = st2_f; st3_t = st2_t;
    st2_v = st1_v; st2_r = st1_r; st2_f = st1_f; st2_t = st1_t;
    st1_v = fast_acc;
    if (fast_acc) begin st1_r = sum[31:0]; st1_f = f; st1_t = tag; end
    for (int i = 3; i > 0; i--) begin
      sv[i] = sv[i-1];
      if (sv[i-1]) begin sr[i] = sr[i-1]; stg[i] = stg[i-1]; end
    end
    sv[0] = slow_acc;
    if (slow_acc) begin sr[0] = sres; stg[0] = tag; end
    @(posedge clk);
    cyc++;
    #2;
    chk("R1 lo_valid", 32'(lo_valid_o), 32'(st1_v));
    if (st1_v) begin
      chk("R1 lo", 32'(lo_o), 32'(st1_r[15:0]));
      chk("R1 lo_tag", 32'(lo_tag_o), 32'(st1_t));
    end
    chk("R2 hi_valid", 32'(hi_valid_o), 32'(st2_v));
    if (st2_v) begin
      chk("R2 hi", 32'(hi_o), 32'(st2_r[31:16]));
      chk("R2 hi_tag", 32'(hi_tag_o), 32'(st2_t));
    end
    chk("R5 flags_valid", 32'(flags_valid_o), 32'(st3_v));
    if (st3_v) begin
      chk("R5 flags", 32'(flags_o), 32'(st3_f));
      chk("R5 flags_tag", 32'(flags_tag_o), 32'(st3_t));
    end
    chk("R6 slow_valid", 32'(slow_valid_o), 32'(sv[3]));
    if (sv[3]) begin
      chk("R6 slow", slow_o, sr[3]);
      chk("R6 slow_tag", 32'(slow_tag_o), 32'(stg[3]));
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                       input bit f_a, input bit f_b, output int stalls);
    bit s;
    valid = 1'b1; op = o; a = x; b = y; fa = f_a; fb = f_b; tag = tag_ctr;
    stalls = 0;
    do begin
      tick(s);
      if (s) stalls++;
    end while (s && stalls < 20);
    tag_ctr++;
  endtask

  task automatic idle(input int n);
    bit s;
    valid = 1'b0; fa = 1'b0; fb = 1'b0;
    for (int i = 0; i < n; i++) tick(s);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'h0000_FFFF, 32'h0001_0000,
                                       32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};

  initial begin
    int st, c0;
    // R10: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R10 lo_valid", 32'(lo_valid_o), 0);
    chk("R10 hi_valid", 32'(hi_valid_o), 0);
    chk("R10 flags_valid", 32'(flags_valid_o), 0);
    chk("R10 slow_valid", 32'(slow_valid_o), 0);
    chk("R10 stall", 32'(stall_o), 0);
    rst_n = 1'b1;
    idle(2);

    // R3 R1 R2 R5: independent add/sub sweep over corner operands, back to back
    scen = "R3 sweep";
    for (int o = 0; o < 2; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) issue(2'(o), VALS[i], VALS[j], 0, 0, st);
    idle(4);

    // R4: chain of 100 dependent adds, one per cycle
    scen = "R4 add chain";
    c0 = cyc;
    issue(2'd0, 32'h0000_FFF0, 32'h1, 0, 0, st);
    for (int i = 1; i < 100; i++) begin
      issue(2'd0, 32'h0, 32'(i * 4093), 1, 0, st);
      chk("R4 no stall in chain", 32'(st), 0);
    end
    chk("R4 chain cycles", 32'(cyc - c0), 32'd100);
    // R4: subtract chain through second source
    scen = "R4 sub chain";
    for (int i = 0; i < 30; i++) issue(2'd1, 32'(32'h8000_0000 + i * 77777), 32'h0, 0, 1, st);
    // R4: both sources forwarded (doubling crosses the half boundary)
    scen = "R4 double chain";
    issue(2'd0, 32'h0000_C001, 32'h0, 0, 0, st);
    for (int i = 0; i < 20; i++) issue(2'd0, 32'h0, 32'h0, 1, 1, st);
    idle(4);

    // R6 R7: shift sweep, forward flags toggled and ignored
    scen = "R6 R7 shifts";
    for (int o = 2; o < 4; o++)
      for (int i = 4; i < 8; i++)
        for (int s = 0; s < 32; s++)
          issue(2'(o), VALS[i], 32'(s) | 32'hFFFF_FF00, s[0], s[1], st);
    idle(6);

    // R8 R9: dependent add waits for the shift and takes its full result
    scen = "R8 R9 stall";
    issue(2'd2, 32'h3, 32'd20, 0, 0, st);
    issue(2'd0, 32'h0, 32'h0001_FFFF, 1, 0, st);
    chk("R8 stall cycles", 32'(st), 32'd3);
    idle(6);
    // R8: independent add behind a shift is not stalled
    scen = "R8 independent";
    issue(2'd3, 32'hF000_0000, 32'd4, 0, 0, st);
    issue(2'd1, 32'h10, 32'h20, 0, 0, st);
    chk("R8 independent stall", 32'(st), 0);
    idle(6);
    // R9: shift return coincides with a fast low half; fast result is forwarded
    scen = "R9 tie";
    issue(2'd2, 32'h1, 32'd8, 0, 0, st);
    issue(2'd0, 32'd10, 32'd0, 0, 0, st);
    issue(2'd0, 32'd20, 32'd0, 0, 0, st);
    issue(2'd0, 32'h0001_8000, 32'h0000_8000, 0, 0, st);
    issue(2'd0, 32'h0, 32'd1, 1, 0, st);
    chk("R9 tie no stall", 32'(st), 0);
    idle(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule